// File: doc/BRIEF.md
# Four-Client SDRAM Row-Burst Arbiter

This block lets four independent clients share one SDRAM command port. Each client raises a request and supplies a bank, a row, a starting column slot, a direction and a count of 8-beat column commands. The arbiter grants one client at a time. It opens the row with ACTIVE, streams the column commands at a fixed spacing and closes the row with PRECHARGE. It then pulses done to the client and drops the grant in that same cycle. No row stays open between grants, so every grant starts with all banks idle.

Refresh is handled as an internal fifth requester. A free-running interval counter adds one owed refresh each time it expires, up to a ceiling. Owed refreshes win over waiting clients, but they never interrupt a grant that is in progress. A backlog is drained as back-to-back REFRESH commands spaced by the refresh cycle time. All command spacings are parameters, and every cycle with no command carries NOP.

Top module: `sdram_burst_arbiter`

## Requirements
- R1: At most one grant bit is high at any time, and a grant stays high from its ACTIVE up to and including its PRECHARGE cycle.
- R2: Clients are searched round-robin, starting from the client after the last one granted. After reset, client 0 has the first turn.
- R3: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5. A grant appears in the same cycle as its ACTIVE, which carries the client's bank and row.
- R4: The first column command follows ACTIVE by exactly T_RCD cycles. Further column commands of the same grant follow each other by exactly T_CCD cycles.
- R5: PRECHARGE goes to the granted bank exactly T_WRP cycles after the last WRITE, or exactly T_RDP cycles after the last READ. The next ACTIVE or REFRESH comes no sooner than T_RP cycles after PRECHARGE.
- R6: Column commands are WRITE when the latched direction bit is 1 and READ when it is 0. The column output equals 8 times the slot, where the slot starts at the requested slot and rises by one per command.
- R7: The number of column commands is the count field, with a count of 0 treated as 1. A request that would run past the last slot of the row is cut at the row end, and its truncation flag is high together with its done pulse.
- R8: Each REF_INT cycles the refresh timer adds one owed refresh. The owed total saturates at REF_MAX.
- R9: An owed refresh is issued ahead of any waiting client, only when no client holds a grant. Successive REFRESH commands are exactly T_RFC cycles apart when more are owed.
- R10: Done is a one-cycle pulse to the granted client in the cycle after its PRECHARGE. The grant falls in that same cycle.
- R11: Every cycle without a command drives NOP with zero bank, row and column.
- R12: While reset is held, the arbiter drives NOP with no grant and no done, and the refresh timer and owed count are cleared.
- R13: A client's fields are captured at grant. Changes to them while the grant is held have no effect on that grant's commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cli_req | input | NCLI | Request per client |
| cli_wr | input | NCLI | Direction per client, 1 = write |
| cli_bank | input | NCLI*BANK_W | Bank per client |
| cli_row | input | NCLI*ROW_W | Row per client |
| cli_slot | input | NCLI*(COL_W-3) | Starting column slot (column/8) per client |
| cli_cnt | input | NCLI*CNT_W | Number of 8-beat column commands per client |
| cli_gnt | output | NCLI | One-hot grant |
| cli_done | output | NCLI | One-cycle done pulse per client |
| cli_trunc | output | 1 | Truncation flag, valid with done |
| sd_cmd | output | 3 | Command code |
| sd_bank | output | BANK_W | Command bank |
| sd_row | output | ROW_W | Row with ACTIVE |
| sd_col | output | COL_W | Column with READ/WRITE |

## Verification
All outputs are registered. A decision taken from the inputs present before a clock edge appears on the ports just after that edge: a grant and its ACTIVE appear together, and the first column command follows T_RCD edges later. Done appears one edge after PRECHARGE, and an owed refresh appears one edge after the timer wraps, if the arbiter is idle and no spacing is pending. The bench's behavioural model advances on the same edge as the design and is compared at the falling edge, so every field is checked in the exact cycle it is due. Directed scenarios cover grant order, truncation, field changes during a grant and refresh saturation.

// File: rtl/sdarb_pkg.sv
`timescale 1ns/1ps
package sdarb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } sd_cmd_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdarb_refresh.sv
`timescale 1ns/1ps
module sdarb_refresh #(
  parameter int REF_INT = 780,
  parameter int REF_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic taken,
  output logic owed
);
  localparam int TW = $clog2(REF_INT);
  localparam int PW = $clog2(REF_MAX + 1);

  logic [TW-1:0] tmr_q, tmr_n;
  logic [PW-1:0] pend_q, pend_n;
  logic          tick;

  assign tick = (tmr_q == TW'(REF_INT - 1));
  assign owed = (pend_q != '0);

  always_comb begin
    tmr_n  = tick ? '0 : tmr_q + 1'b1;
    pend_n = pend_q;
    if (tick && !taken && (pend_q != PW'(REF_MAX)))
      pend_n = pend_q + 1'b1;
    else if (taken && !tick)
      pend_n = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= '0;
    end else begin
      tmr_q  <= tmr_n;
      pend_q <= pend_n;
    end
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(REF_MAX)); // R8
  AST_TAKE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> owed); // R9
endmodule

// File: rtl/sdarb_rr_pick.sv
`timescale 1ns/1ps
module sdarb_rr_pick #(
  parameter int NCLI = 4,
  localparam int IW = $clog2(NCLI)
) (
  input  logic [NCLI-1:0] req,
  input  logic [IW-1:0]   last,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    int c;
    any = 1'b0;
    idx = '0;
    // farthest candidate first, so the nearest one after 'last' wins
    for (int k = NCLI; k >= 1; k--) begin
      c = (int'(last) + k) % NCLI;
      if (req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/sdarb_span.sv
`timescale 1ns/1ps
module sdarb_span #(
  parameter int SLOT_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  eff,
  output logic              trunc
);
  localparam int NSLOT = 2 ** SLOT_W;

  always_comb begin
    int avail;
    int want;
    avail = NSLOT - int'(slot);
    want  = (cnt == '0) ? 1 : int'(cnt);
    trunc = (want > avail);
    eff   = trunc ? CNT_W'(avail) : CNT_W'(want);
  end
endmodule

// File: rtl/sdram_burst_arbiter.sv
`timescale 1ns/1ps
module sdram_burst_arbiter import sdarb_pkg::*; #(
  parameter int NCLI    = 4,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int CNT_W   = 8,
  parameter int T_RCD   = 3,
  parameter int T_CCD   = 4,
  parameter int T_WRP   = 6,
  parameter int T_RDP   = 4,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 10,
  parameter int REF_INT = 780,
  parameter int REF_MAX = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCLI-1:0]           cli_req,
  input  logic [NCLI-1:0]           cli_wr,
  input  logic [NCLI*BANK_W-1:0]    cli_bank,
  input  logic [NCLI*ROW_W-1:0]     cli_row,
  input  logic [NCLI*(COL_W-3)-1:0] cli_slot,
  input  logic [NCLI*CNT_W-1:0]     cli_cnt,
  output logic [NCLI-1:0]           cli_gnt,
  output logic [NCLI-1:0]           cli_done,
  output logic                      cli_trunc,
  output logic [2:0]                sd_cmd,
  output logic [BANK_W-1:0]         sd_bank,
  output logic [ROW_W-1:0]          sd_row,
  output logic [COL_W-1:0]          sd_col
);
  localparam int IW   = $clog2(NCLI);
  localparam int SW   = COL_W - 3;
  localparam int GMAX = imax(imax(imax(T_RCD, T_CCD), imax(T_WRP, T_RDP)), imax(T_RP, T_RFC));
  localparam int WW   = $clog2(GMAX + 1);

  seq_st_e             st_q, st_n;
  logic [WW-1:0]       wait_q, wait_n;
  logic [IW-1:0]       last_q, last_n;
  logic [CNT_W-1:0]    left_q, left_n;
  logic [SW-1:0]       slot_q, slot_n;
  logic                wr_q, wr_n, trq_q, trq_n, close_q, close_n;
  logic [BANK_W-1:0]   bank_q, bank_n;
  logic [NCLI-1:0]     gnt_q, gnt_n, done_q, done_n;
  logic                trout_q, trout_n;
  sd_cmd_e             cmd_q, cmd_n;
  logic [BANK_W-1:0]   ba_q, ba_n;
  logic [ROW_W-1:0]    ra_q, ra_n;
  logic [COL_W-1:0]    ca_q, ca_n;

  logic                pk_any, ref_owed, ref_take;
  logic [IW-1:0]       pk_idx;
  logic [NCLI*CNT_W-1:0] eff_all;
  logic [NCLI-1:0]     trunc_all;

  sdarb_rr_pick #(.NCLI(NCLI)) u_pick (
    .req(cli_req), .last(last_q), .any(pk_any), .idx(pk_idx));

  sdarb_refresh #(.REF_INT(REF_INT), .REF_MAX(REF_MAX)) u_ref (
    .clk(clk), .rst_n(rst_n), .taken(ref_take), .owed(ref_owed));

  for (genvar g = 0; g < NCLI; g++) begin : g_span
    sdarb_span #(.SLOT_W(SW), .CNT_W(CNT_W)) u_span (
      .slot (cli_slot[g*SW +: SW]),
      .cnt  (cli_cnt[g*CNT_W +: CNT_W]),
      .eff  (eff_all[g*CNT_W +: CNT_W]),
      .trunc(trunc_all[g]));
  end

  always_comb begin
    st_n = st_q;   wait_n = wait_q; last_n = last_q; left_n = left_q;
    slot_n = slot_q; wr_n = wr_q;   trq_n = trq_q;   bank_n = bank_q;
    close_n = 1'b0; gnt_n = gnt_q;  done_n = '0;     trout_n = 1'b0;
    cmd_n = CMD_NOP; ba_n = '0;     ra_n = '0;       ca_n = '0;
    ref_take = 1'b0;
    if (close_q) begin
      done_n  = gnt_q;
      trout_n = trq_q;
      gnt_n   = '0;
    end
    case (st_q)
      ST_IDLE: begin
        if (wait_q != '0) begin
          wait_n = wait_q - 1'b1;
        end else if (ref_owed) begin
          cmd_n    = CMD_REF;
          ref_take = 1'b1;
          wait_n   = WW'(T_RFC - 1);
        end else if (pk_any) begin
          last_n = pk_idx;
          gnt_n  = NCLI'(1) << pk_idx;
          wr_n   = cli_wr[pk_idx];
          bank_n = cli_bank[pk_idx*BANK_W +: BANK_W];
          slot_n = cli_slot[pk_idx*SW +: SW];
          left_n = eff_all[pk_idx*CNT_W +: CNT_W];
          trq_n  = trunc_all[pk_idx];
          cmd_n  = CMD_ACT;
          ba_n   = cli_bank[pk_idx*BANK_W +: BANK_W];
          ra_n   = cli_row[pk_idx*ROW_W +: ROW_W];
          wait_n = WW'(T_RCD - 1);
          st_n   = ST_BUSY;
        end
      end
      default: begin
        if (wait_q != '0) begin
          wait_n = wait_q - 1'b1;
        end else if (left_q != '0) begin
          cmd_n  = wr_q ? CMD_WR : CMD_RD;
          ba_n   = bank_q;
          ca_n   = {slot_q, 3'b000};
          slot_n = slot_q + 1'b1;
          left_n = left_q - 1'b1;
          if (left_q != CNT_W'(1)) wait_n = WW'(T_CCD - 1);
          else                     wait_n = wr_q ? WW'(T_WRP - 1) : WW'(T_RDP - 1);
        end else begin
          cmd_n   = CMD_PRE;
          ba_n    = bank_q;
          wait_n  = WW'(T_RP - 1);
          close_n = 1'b1;
          st_n    = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; wait_q <= '0; last_q <= IW'(NCLI - 1); left_q <= '0;
      slot_q <= '0; wr_q <= 1'b0; trq_q <= 1'b0; close_q <= 1'b0; bank_q <= '0;
      gnt_q <= '0; done_q <= '0; trout_q <= 1'b0;
      cmd_q <= CMD_NOP; ba_q <= '0; ra_q <= '0; ca_q <= '0;
    end else begin
      st_q <= st_n; wait_q <= wait_n; last_q <= last_n; left_q <= left_n;
      slot_q <= slot_n; wr_q <= wr_n; trq_q <= trq_n; close_q <= close_n; bank_q <= bank_n;
      gnt_q <= gnt_n; done_q <= done_n; trout_q <= trout_n;
      cmd_q <= cmd_n; ba_q <= ba_n; ra_q <= ra_n; ca_q <= ca_n;
    end
  end

  assign cli_gnt   = gnt_q;
  assign cli_done  = done_q;
  assign cli_trunc = trout_q;
  assign sd_cmd    = cmd_q;
  assign sd_bank   = ba_q;
  assign sd_row    = ra_q;
  assign sd_col    = ca_q;

  AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cli_gnt)); // R1
  AST_GNT_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_ACT) |-> (cli_gnt != '0)); // R3
  AST_ACT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_ACT) |=> (sd_cmd == CMD_NOP || sd_cmd == CMD_RD || sd_cmd == CMD_WR)); // R4
  AST_REF_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_REF) |-> (cli_gnt == '0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_done != '0) |=> (cli_done == '0)); // R10
  AST_DONE_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_done != '0) |-> ($past(sd_cmd) == CMD_PRE)); // R10
endmodule

// File: tb/sim_sdram_burst_arbiter.sv
`timescale 1ns/1ps
module sim_sdram_burst_arbiter;
  localparam int N = 4, BW = 2, RW = 8, CW = 9, NW = 7, SW = CW - 3, NSLOT = 64;
  localparam int T_RCD = 3, T_CCD = 4, T_WRP = 6, T_RDP = 4, T_RP = 3, T_RFC = 10;
  localparam int REF_INT = 40, REF_MAX = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [N-1:0] b_req, b_wr;
  logic [BW-1:0] b_bank [N];
  logic [RW-1:0] b_row [N];
  logic [SW-1:0] b_slot [N];
  logic [NW-1:0] b_cnt [N];
  logic [N*BW-1:0] f_bank;
  logic [N*RW-1:0] f_row;
  logic [N*SW-1:0] f_slot;
  logic [N*NW-1:0] f_cnt;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      f_bank[c*BW +: BW] = b_bank[c];
      f_row[c*RW +: RW]  = b_row[c];
      f_slot[c*SW +: SW] = b_slot[c];
      f_cnt[c*NW +: NW]  = b_cnt[c];
    end
  end

  logic [N-1:0] cli_gnt, cli_done;
  logic cli_trunc;
  logic [2:0] sd_cmd;
  logic [BW-1:0] sd_bank;
  logic [RW-1:0] sd_row;
  logic [CW-1:0] sd_col;

  sdram_burst_arbiter #(.NCLI(N), .BANK_W(BW), .ROW_W(RW), .COL_W(CW), .CNT_W(NW),
    .T_RCD(T_RCD), .T_CCD(T_CCD), .T_WRP(T_WRP), .T_RDP(T_RDP), .T_RP(T_RP),
    .T_RFC(T_RFC), .REF_INT(REF_INT), .REF_MAX(REF_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .cli_req(b_req), .cli_wr(b_wr), .cli_bank(f_bank),
    .cli_row(f_row), .cli_slot(f_slot), .cli_cnt(f_cnt), .cli_gnt(cli_gnt),
    .cli_done(cli_done), .cli_trunc(cli_trunc), .sd_cmd(sd_cmd), .sd_bank(sd_bank),
    .sd_row(sd_row), .sd_col(sd_col));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit rnd_on = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int oh_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_busy, m_wait, m_last, m_left, m_slot, m_pend, m_tick;
  bit m_wr, m_trunc, m_close;
  int m_bank;
  int e_cmd, e_bank, e_row, e_col, e_trunc;
  logic [N-1:0] e_gnt, e_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wait = 0; m_last = N - 1; m_left = 0; m_slot = 0; m_pend = 0; m_tick = 0;
      m_wr = 0; m_trunc = 0; m_close = 0; m_bank = 0;
      e_cmd = 0; e_bank = 0; e_row = 0; e_col = 0; e_trunc = 0; e_gnt = '0; e_done = '0;
    end else begin
      bit tick, took;
      tick = (m_tick == REF_INT - 1);
      m_tick = tick ? 0 : m_tick + 1;
      took = 0;
      e_cmd = 0; e_bank = 0; e_row = 0; e_col = 0; e_done = '0; e_trunc = 0;
      if (m_close) begin
        e_done = e_gnt; e_trunc = m_trunc; e_gnt = '0; m_close = 0;
      end
      if (m_wait > 0) begin
        m_wait--;
      end else if (!m_busy) begin
        if (m_pend > 0) begin
          e_cmd = 5; took = 1; m_wait = T_RFC - 1;
        end else begin
          int pick;
          pick = -1;
          for (int k = 1; k <= N; k++)
            if (pick < 0 && b_req[(m_last + k) % N]) pick = (m_last + k) % N;
          if (pick >= 0) begin
            int want, avail;
            m_last = pick; m_busy = 1;
            e_gnt = '0; e_gnt[pick] = 1'b1;
            m_wr = b_wr[pick]; m_bank = b_bank[pick]; m_slot = b_slot[pick];
            want = (b_cnt[pick] == 0) ? 1 : b_cnt[pick];
            avail = NSLOT - m_slot;
            m_trunc = (want > avail);
            m_left = m_trunc ? avail : want;
            e_cmd = 1; e_bank = m_bank; e_row = b_row[pick];
            m_wait = T_RCD - 1;
          end
        end
      end else if (m_left > 0) begin
        e_cmd = m_wr ? 3 : 2; e_bank = m_bank; e_col = m_slot * 8;
        m_slot++; m_left--;
        m_wait = (m_left > 0) ? T_CCD - 1 : (m_wr ? T_WRP - 1 : T_RDP - 1);
      end else begin
        e_cmd = 4; e_bank = m_bank; m_busy = 0; m_wait = T_RP - 1; m_close = 1;
      end
      if (tick && !took && m_pend < REF_MAX) m_pend++;
      else if (took && !tick) m_pend--;
    end
  end

  // ---------------- comparison at the falling edge ----------------
  int act_own[$];
  int act_row[$];
  int done_tr [N];

  always @(negedge clk) begin
    if (rst_n) begin
      string ctag;
      cyc++;
      case (e_cmd)
        1: ctag = "R3"; 2, 3: ctag = "R4"; 4: ctag = "R5"; 5: ctag = "R9"; default: ctag = "R11";
      endcase
      chk(sd_cmd == 3'(e_cmd), ctag, "command", sd_cmd, e_cmd);
      chk(cli_gnt == e_gnt, "R1", "grant vector", cli_gnt, e_gnt);
      chk(sd_bank == BW'(e_bank) && sd_row == RW'(e_row), "R6", "bank/row", {sd_bank, sd_row}, {BW'(e_bank), RW'(e_row)});
      chk(sd_col == CW'(e_col), "R6", "column", sd_col, e_col);
      chk(cli_done == e_done, "R10", "done vector", cli_done, e_done);
      chk(cli_trunc == e_trunc[0], "R7", "truncation flag", cli_trunc, e_trunc);
      if (sd_cmd == 3'd1) begin
        act_own.push_back(oh_idx(cli_gnt));
        act_row.push_back(sd_row);
      end
      for (int c = 0; c < N; c++) if (cli_done[c]) done_tr[c] = cli_trunc;
    end
  end

  // ---------------- client drivers ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < N; c++) begin
        if (cli_done[c]) b_req[c] = 1'b0;
        else if (rnd_on && !b_req[c] && ($urandom % 8 == 0)) begin
          b_wr[c] = 1'($urandom); b_bank[c] = BW'($urandom); b_row[c] = RW'($urandom);
          b_slot[c] = SW'($urandom_range(0, NSLOT - 1)); b_cnt[c] = NW'($urandom_range(0, 12));
          b_req[c] = 1'b1;
        end else if (rnd_on && cli_gnt[c] && ($urandom % 4 == 0)) begin
          b_row[c] = RW'($urandom); b_cnt[c] = NW'($urandom_range(0, 12)); b_wr[c] = ~b_wr[c]; // R13
        end
      end
    end
  end

  task automatic raise(input int c, input bit wr, input int bank, input int row, input int slot, input int cnt);
    b_wr[c] = wr; b_bank[c] = BW'(bank); b_row[c] = RW'(row);
    b_slot[c] = SW'(slot); b_cnt[c] = NW'(cnt); b_req[c] = 1'b1;
  endtask

  task automatic drain();
    while (b_req != '0) @(negedge clk);
    repeat (T_RP + 2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int refs;
    rst_n = 1'b0; b_req = '0; b_wr = '0;
    for (int c = 0; c < N; c++) begin b_bank[c] = '0; b_row[c] = '0; b_slot[c] = '0; b_cnt[c] = '0; end
    repeat (4) @(negedge clk);
    chk(sd_cmd == 3'd0, "R12", "command in reset", sd_cmd, 0);
    chk(cli_gnt == '0, "R12", "grant in reset", cli_gnt, 0);
    chk(cli_done == '0 && cli_trunc == 1'b0, "R12", "done in reset", cli_done, 0);
    rst_n = 1'b1;

    // all four at once: order, truncation, zero count
    raise(0, 1, 0, 10, 0, 2);
    raise(1, 0, 1, 20, 60, 10);
    raise(2, 1, 2, 30, 5, 0);
    raise(3, 0, 3, 40, 8, 3);
    drain();
    chk(act_own.size() >= 4, "R2", "grants seen", act_own.size(), 4);
    for (int i = 0; i < 4 && i < act_own.size(); i++)
      chk(act_own[i] == i, "R2", "round-robin order", act_own[i], i);
    chk(done_tr[1] == 1, "R7", "flag on cut request", done_tr[1], 1);
    chk(done_tr[0] == 0, "R7", "flag on fitting request", done_tr[0], 0);

    // fields changed under an active grant
    act_row.delete(); act_own.delete();
    raise(2, 0, 1, 77, 3, 4);
    while (cli_gnt[2] == 1'b0) @(negedge clk);
    b_row[2] = 8'd5; b_wr[2] = 1'b1; b_cnt[2] = 7'd1; // R13
    drain();
    chk(act_row.size() == 1 && act_row[0] == 77, "R13", "row of held grant", act_row.size() > 0 ? act_row[0] : -1, 77);

    // long burst lets owed refreshes pile up to the ceiling
    raise(0, 1, 0, 3, 0, 60);
    while (cli_done[0] == 1'b0) @(negedge clk);
    refs = 0;
    repeat (T_RP + (REF_MAX + 1) * T_RFC + 2) begin
      @(negedge clk);
      if (sd_cmd == 3'd5) refs++;
    end
    chk(refs >= REF_MAX && refs <= REF_MAX + 1, "R8", "refreshes after long burst", refs, REF_MAX);

    // mixed random traffic
    rnd_on = 1;
    repeat (4000) @(negedge clk);
    rnd_on = 0;
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule